// File: doc/BRIEF.md
# Vertical Chroma Halver (4:2:2 to 4:2:0)

This block sits in a video pipeline after horizontal chroma decimation. It receives a 4:2:2 YCbCr stream, one beat per pixel. Each beat carries a luma sample and one chroma sample, and the chroma alternates Cb, Cr along the line. A start-of-frame flag marks the first beat of a frame and an end-of-line flag marks the last beat of each line. The block halves the vertical chroma resolution. Lines are counted from zero at each frame start. The chroma of every even line is kept in a line store. On the following odd line, each chroma sample is blended with the stored sample from the same column, so the output chroma sits between the two source lines.

Two blending modes are offered. Pair-average mode weights both lines equally. Field-weighted mode, used for interlaced material, weights the two lines 3:1 for a top field or 1:3 for a bottom field, chosen by a field input. With the enable low, the stream passes through untouched. Luma and the line and frame flags always pass through.

Both stream edges use valid/ready. An input beat is taken in a cycle where `in_valid` and `in_ready` are both high. A beat is delivered in a cycle where `out_valid` and `out_ready` are both high. There is a single registered output stage, so `in_ready` is high whenever that stage is empty or is being drained in the same cycle. While the output is stalled, the presented beat is held stable. The control inputs are sampled with each accepted beat.

Top module: `chroma_v420`

## Requirements
- R1: While `en` is low on an accepted beat, the output beat carries the same chroma and has `out_chroma_vld` = 1.
- R2: Every accepted beat produces exactly one output beat, in order, with the same luma, `sof` and `eol`.
- R3: When `en` is high, a beat on an even line (counting the first line of a frame as line 0) is output with `out_chroma_vld` = 0 and `out_chroma` = 0.
- R4: When `en` is high and `field_mode` = 0, a beat on an odd line outputs chroma (2·A + 2·B + 2) >> 2. A is the chroma of the same column on the previous line and B is the current chroma.
- R5: When `en` is high, `field_mode` = 1 and `bottom_field` = 0, an odd-line beat outputs (3·A + B + 2) >> 2.
- R6: When `en` is high, `field_mode` = 1 and `bottom_field` = 1, an odd-line beat outputs (A + 3·B + 2) >> 2.
- R7: Pairing is done by column index. The column restarts at 0 after an end-of-line beat and on a start-of-frame beat, so Cb is blended with Cb and Cr with Cr.
- R8: A start-of-frame beat always begins line 0, even if the previous frame ended after an odd number of lines.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output beat stays unchanged.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Subsampling enable; low selects pass-through |
| field_mode | input | 1 | 0: pair average, 1: field-weighted |
| bottom_field | input | 1 | In field-weighted mode, 1 selects bottom-field weights |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_luma | input | DW | Luma sample |
| in_chroma | input | DW | Chroma sample (Cb on even columns, Cr on odd) |
| in_sof | input | 1 | First beat of a frame |
| in_eol | input | 1 | Last beat of a line |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_luma | output | DW | Luma sample |
| out_chroma | output | DW | Blended or passed chroma, 0 when absent |
| out_chroma_vld | output | 1 | Chroma present on this beat |
| out_sof | output | 1 | First beat of a frame |
| out_eol | output | 1 | Last beat of a line |

## Verification
The bench feeds the extreme pair 255 over 0 through every weighting. The expected results are 128, 191 and 64, so a design that truncates instead of rounding, or that swaps the top and bottom weights, gives a visibly different value. One frame is cut short after an odd number of lines and the next frame starts directly. A parity counter that is not cleared by the start-of-frame flag would then leave chroma on the wrong lines. Frames of different widths and a pass-through frame in between check that the column index restarts correctly, so a Cb sample is never blended with a Cr sample. Irregular stalls on both sides check that a held output beat is not overwritten or lost.

// File: rtl/chroma_v420_pkg.sv
package chroma_v420_pkg;
  typedef enum logic {
    FM_PAIR_AVG       = 1'b0,
    FM_FIELD_WEIGHTED = 1'b1
  } fmode_e;

  // fraction bits carried through the weighted sum, weights sum to 2**FRAC_BITS
  localparam int unsigned FRAC_BITS  = 2;
  localparam int unsigned ROUND_BIAS = 1 << (FRAC_BITS - 1);
endpackage

// File: rtl/chroma_line_store.sv
module chroma_line_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/line_phase_tracker.sv
module line_phase_tracker #(
  parameter int unsigned COLS = 64,
  localparam int unsigned CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          sof,
  input  logic          eol,
  output logic [CW-1:0] cur_col,
  output logic          cur_odd
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  logic [CW-1:0] col_q;
  logic          odd_q;

  // a frame start forces column 0 on line 0 for the beat that carries it
  assign cur_col = sof ? '0 : col_q;
  assign cur_odd = sof ? 1'b0 : odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      odd_q <= 1'b0;
    end else if (step) begin
      if (eol) begin
        col_q <= '0;
        odd_q <= ~cur_odd;
      end else begin
        col_q <= (cur_col == LAST_COL) ? cur_col : cur_col + 1'b1;
        odd_q <= cur_odd;
      end
    end
  end
endmodule

// File: rtl/chroma_blend.sv
module chroma_blend
  import chroma_v420_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned SW = DW + FRAC_BITS
) (
  input  logic [DW-1:0] upper_c,
  input  logic [DW-1:0] lower_c,
  input  fmode_e        mode,
  input  logic          bottom,
  output logic [DW-1:0] mixed_c
);
  logic [FRAC_BITS-1:0] w_up;
  logic [FRAC_BITS-1:0] w_lo;
  logic [SW-1:0]        acc;

  always_comb begin
    unique case (mode)
      FM_PAIR_AVG: begin
        w_up = FRAC_BITS'(2);
        w_lo = FRAC_BITS'(2);
      end
      default: begin
        w_up = bottom ? FRAC_BITS'(1) : FRAC_BITS'(3);
        w_lo = bottom ? FRAC_BITS'(3) : FRAC_BITS'(1);
      end
    endcase
  end

  always_comb begin
    acc = ({{FRAC_BITS{1'b0}}, upper_c} * SW'(w_up))
        + ({{FRAC_BITS{1'b0}}, lower_c} * SW'(w_lo))
        + SW'(ROUND_BIAS);
    mixed_c = acc[SW-1:FRAC_BITS];
  end
endmodule

// File: rtl/chroma_v420.sv
module chroma_v420
  import chroma_v420_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MAX_COLS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          field_mode,
  input  logic          bottom_field,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_luma,
  input  logic [DW-1:0] in_chroma,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_luma,
  output logic [DW-1:0] out_chroma,
  output logic          out_chroma_vld,
  output logic          out_sof,
  output logic          out_eol
);
  localparam int unsigned CW = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;

  logic          take;
  logic [CW-1:0] col;
  logic          odd_line;
  logic [DW-1:0] stored_c;
  logic [DW-1:0] blended_c;
  fmode_e        mode;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign mode     = field_mode ? FM_FIELD_WEIGHTED : FM_PAIR_AVG;

  line_phase_tracker #(.COLS(MAX_COLS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (take),
    .sof     (in_sof),
    .eol     (in_eol),
    .cur_col (col),
    .cur_odd (odd_line)
  );

  chroma_line_store #(.DW(DW), .DEPTH(MAX_COLS)) u_store (
    .clk     (clk),
    .wr_en   (take && en && !odd_line),
    .wr_addr (col),
    .wr_data (in_chroma),
    .rd_addr (col),
    .rd_data (stored_c)
  );

  chroma_blend #(.DW(DW)) u_blend (
    .upper_c (stored_c),
    .lower_c (in_chroma),
    .mode    (mode),
    .bottom  (bottom_field),
    .mixed_c (blended_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_luma       <= '0;
      out_chroma     <= '0;
      out_chroma_vld <= 1'b0;
      out_sof        <= 1'b0;
      out_eol        <= 1'b0;
    end else if (take) begin
      out_luma <= in_luma;
      out_sof  <= in_sof;
      out_eol  <= in_eol;
      if (!en) begin
        out_chroma     <= in_chroma;
        out_chroma_vld <= 1'b1;
      end else if (odd_line) begin
        out_chroma     <= blended_c;
        out_chroma_vld <= 1'b1;
      end else begin
        out_chroma     <= '0;
        out_chroma_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chroma_v420_chk.sv
module chroma_v420_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_luma,
  input logic [DW-1:0] in_chroma,
  input logic          in_sof,
  input logic          in_eol,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_luma,
  input logic [DW-1:0] out_chroma,
  input logic          out_chroma_vld,
  input logic          out_sof,
  input logic          out_eol
);
  logic acc_beat;
  assign acc_beat = rst_n && in_valid && in_ready;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_luma)
      && $stable(out_chroma) && $stable(out_chroma_vld));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beat && !en |=> out_chroma_vld && out_chroma == $past(in_chroma));

  // R2
  luma_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beat |=> out_valid && out_luma == $past(in_luma)
      && out_sof == $past(in_sof) && out_eol == $past(in_eol));

  // R8
  frame_start_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_beat && en && in_sof |=> !out_chroma_vld);

  // R3
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_chroma_vld |-> out_chroma == '0);
endmodule

bind chroma_v420 chroma_v420_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en             (en),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_luma        (in_luma),
  .in_chroma      (in_chroma),
  .in_sof         (in_sof),
  .in_eol         (in_eol),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_luma       (out_luma),
  .out_chroma     (out_chroma),
  .out_chroma_vld (out_chroma_vld),
  .out_sof        (out_sof),
  .out_eol        (out_eol)
);

// File: tb/test_chroma_v420.sv
module test_chroma_v420;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, field_mode = 1'b0, bottom_field = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0] in_luma = '0, in_chroma = '0;
  logic       in_ready, out_valid, out_chroma_vld, out_sof, out_eol;
  logic       out_ready = 1'b0;
  logic [7:0] out_luma, out_chroma;

  always #4 clk = ~clk;

  chroma_v420 #(.DW(8), .MAX_COLS(64)) i_chroma_v420 (
    .clk(clk), .rst_n(rst_n), .en(en), .field_mode(field_mode),
    .bottom_field(bottom_field), .in_valid(in_valid), .in_ready(in_ready),
    .in_luma(in_luma), .in_chroma(in_chroma), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_luma(out_luma),
    .out_chroma(out_chroma), .out_chroma_vld(out_chroma_vld),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  typedef struct packed {
    logic [7:0] y; logic [7:0] c; logic sof; logic eol;
    logic en; logic fm; logic bot;
  } beat_t;
  typedef struct packed {
    logic [7:0] y; logic [7:0] c; logic cv; logic sof; logic eol; logic [3:0] req;
  } exp_t;

  beat_t stim[$];
  exp_t  expq[$];
  int    checks = 0, fails = 0;
  int    mem [64];
  int    m_col = 0, m_odd = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] pix_c(int kind, int seed, int l, int x);
    if (kind == 1) return (((l + x) % 2) == 0) ? 8'd255 : 8'd0;
    return 8'((seed + x * 53 + l * 97) & 255);
  endfunction

  // fpat: 0 top, 1 bottom, 2 top on first pair then bottom
  task automatic add_frame(int w, int lines, bit e, bit fm, int fpat, int kind, int seed);
    for (int l = 0; l < lines; l++) begin
      for (int x = 0; x < w; x++) begin
        beat_t b;
        b.y   = 8'((seed * 7 + l * 16 + x) & 255);
        b.c   = pix_c(kind, seed, l, x);
        b.sof = (l == 0 && x == 0);
        b.eol = (x == w - 1);
        b.en  = e;
        b.fm  = fm;
        b.bot = (fpat == 1) || (fpat == 2 && l >= 2);
        stim.push_back(b);
      end
    end
  endtask

  function automatic exp_t model(beat_t b);
    exp_t r;
    int a, v;
    if (b.sof) begin m_col = 0; m_odd = 0; end
    r.y = b.y; r.sof = b.sof; r.eol = b.eol;
    if (!b.en) begin
      r.c = b.c; r.cv = 1'b1; r.req = 4'd1;
    end else if (m_odd == 0) begin
      mem[m_col] = int'(b.c);
      r.c = 8'd0; r.cv = 1'b0; r.req = b.sof ? 4'd8 : 4'd3;
    end else begin
      a = mem[m_col];
      if (!b.fm) begin v = (2 * a + 2 * int'(b.c) + 2) / 4; r.req = 4'd4; end
      else if (!b.bot) begin v = (3 * a + int'(b.c) + 2) / 4; r.req = 4'd5; end
      else begin v = (a + 3 * int'(b.c) + 2) / 4; r.req = 4'd6; end
      r.c = 8'(v); r.cv = 1'b1;
    end
    if (b.eol) begin m_col = 0; m_odd = 1 - m_odd; end
    else m_col = m_col + 1;
    return r;
  endfunction

  function automatic string req_name(logic [3:0] q);
    case (q)
      4'd1: return "R1 R2";
      4'd3: return "R3 R2 R7";
      4'd4: return "R4 R7";
      4'd5: return "R5 R7";
      4'd6: return "R6 R7";
      default: return "R8 R3";
    endcase
  endfunction

  logic       held = 1'b0;
  logic [7:0] held_y, held_c;
  logic       held_cv;

  initial begin
    int cyc = 0;
    add_frame(8, 4, 1'b1, 1'b0, 0, 0, 3);   // pair average
    add_frame(6, 4, 1'b1, 1'b1, 2, 0, 11);  // field-weighted, top then bottom
    add_frame(4, 3, 1'b0, 1'b0, 0, 0, 29);  // pass-through
    add_frame(8, 3, 1'b1, 1'b0, 0, 0, 41);  // odd line count, cut short
    add_frame(6, 2, 1'b1, 1'b1, 0, 1, 0);   // extremes, top
    add_frame(6, 2, 1'b1, 1'b1, 1, 1, 0);   // extremes, bottom
    add_frame(6, 2, 1'b1, 1'b0, 0, 1, 0);   // extremes, average
    add_frame(10, 4, 1'b1, 1'b1, 1, 0, 77); // field-weighted bottom

    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    while ((stim.size() > 0 || expq.size() > 0 || out_valid) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[2:0] != 3'd0) && (lfsr[7:5] != 3'd7);
      in_valid  = (stim.size() > 0) && (lfsr[10:9] != 2'd0);
      if (stim.size() > 0) begin
        in_luma = stim[0].y; in_chroma = stim[0].c; in_sof = stim[0].sof;
        in_eol = stim[0].eol; en = stim[0].en; field_mode = stim[0].fm;
        bottom_field = stim[0].bot;
      end
      #1;
      if (held) begin
        checks++;
        if (!out_valid || out_luma !== held_y || out_chroma !== held_c || out_chroma_vld !== held_cv) begin
          fails++;
          $display("FAIL R9 stall: got v=%b y=%h c=%h cv=%b expected 1 %h %h %b",
                   out_valid, out_luma, out_chroma, out_chroma_vld, held_y, held_c, held_cv);
        end
        checks++;
        if (out_valid && !out_ready && in_ready) begin
          fails++;
          $display("FAIL R9 in_ready: got 1 expected 0 while stalled");
        end
      end
      held = out_valid && !out_ready;
      held_y = out_luma; held_c = out_chroma; held_cv = out_chroma_vld;
      if (out_valid && out_ready) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R2 extra beat: got y=%h expected none", out_luma);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (out_luma !== e.y || out_chroma !== e.c || out_chroma_vld !== e.cv
              || out_sof !== e.sof || out_eol !== e.eol) begin
            fails++;
            $display("FAIL %s: got y=%h c=%h cv=%b sof=%b eol=%b expected y=%h c=%h cv=%b sof=%b eol=%b",
                     req_name(e.req), out_luma, out_chroma, out_chroma_vld, out_sof, out_eol,
                     e.y, e.c, e.cv, e.sof, e.eol);
          end
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(stim[0]));
        void'(stim.pop_front());
      end
    end
    if (cyc >= 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: got %0d beats pending expected 0", expq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule